// File: doc/BRIEF.md
# Paged Code Address Translator

This block sits between a processor's 16-bit code fetch address and a 128K flash array. It turns each code address into a 17-bit physical flash address. The lower 32K of code space always reaches the same physical half-bank, whatever page is selected. The upper 32K is steered by a small page register. Software writes and reads that register through the processor's external data bus at data address C0E0h.

After reset a protected boot image overlays the lower 32K of code space, and a select flag tells the flash subsystem to serve those fetches from the boot array. The upper half of code space is still translated through the page register. A release strobe removes the overlay for good. It also emits a one-cycle restart pulse, so the processor can restart its fetches at 0000h from user flash. Only a new reset brings the overlay back. The translated address, the boot select flag, the read data and the restart pulse are all registered.

Top module: `paged_code_xlat`

## Requirements
- R1: While `rst` is high and in the cycle after it, `flash_addr`, `boot_hit`, `dbus_rdata` and `cpu_restart` are zero. The page value is 0 and the boot overlay is active.
- R2: With the overlay released, a code address in 0000h–7FFFh gives `flash_addr` = {2'b00, code_addr[14:0]} for every page value.
- R3: A code address in 8000h–FFFFh gives `flash_addr[16:15]` = page+1 (page 0 → 01, page 1 → 10, page 2 → 11) and `flash_addr[14:0]` = code_addr[14:0]. A stored page value of 3 selects bank 01, the same as page 0.
- R4: A cycle with `dbus_wr` high and `dbus_addr` = C0E0h loads `dbus_wdata[1:0]` into the page value. The new value governs translations sampled from the next clock on. Writes to any other data address leave the page value unchanged.
- R5: A cycle with `dbus_rd` high and `dbus_addr` = C0E0h returns, one clock later on `dbus_rdata`, the fixed reserved pattern A4h in bits 7:2 together with the page value in bits 1:0. Writes never alter bits 7:2. All other cycles return 00h.
- R6: While the overlay is active, a code address in 0000h–7FFFh raises `boot_hit`, and `flash_addr` carries {2'b00, code_addr[14:0]} as the boot offset. Upper-half addresses never raise `boot_hit`.
- R7: A `boot_release` strobe clears the overlay, and it stays clear until the next reset. Translations sampled in the same clock as the strobe still see the overlay.
- R8: The first `boot_release` after reset raises `cpu_restart` for exactly one cycle, in the cycle after the strobe. Later strobes produce no pulse.
- R9: Every output changes only at a clock edge. A code address sampled at one edge is reflected on `flash_addr` and `boot_hit` after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| code_addr | input | 16 | Processor code fetch address |
| dbus_addr | input | 16 | External data bus address |
| dbus_wdata | input | 8 | Data bus write data |
| dbus_wr | input | 1 | Data bus write strobe, one cycle per write |
| dbus_rd | input | 1 | Data bus read strobe, one cycle per read |
| boot_release | input | 1 | Strobe that removes the boot overlay |
| flash_addr | output | 17 | Translated physical flash address |
| boot_hit | output | 1 | Fetch is served from the boot array |
| dbus_rdata | output | 8 | Registered read data of the page register |
| cpu_restart | output | 1 | One-cycle pulse after the overlay is released |

## Verification
Code addresses are swept over both halves of code space, the boundary values 7FFFh and 8000h included, while the page value cycles through 0, 1, 2 and 3. The low-half patterns show that the common area is independent of the page. The upper-half patterns tell the banks apart and show that page 3 aliases to page 0. Page writes carrying all-ones data, and writes to the neighbouring address C0E1h, separate the writable page field from the fixed reserved bits and from foreign writes. Release strobes are placed before and after the first one, and then a second reset is applied. This shows the overlay cannot come back from software, and that the restart pulse fires only once.

// File: rtl/paged_code_xlat_pkg.sv
package paged_code_xlat_pkg;
  localparam int CODE_AW_DEF   = 16;
  localparam int DATA_AW_DEF   = 16;
  localparam int DW_DEF        = 8;
  localparam int PAGE_BITS_DEF = 2;
  localparam int NUM_PAGES_DEF = 3;
  localparam logic [15:0] PAGE_ADDR_DEF = 16'hC0E0;
  localparam logic [7:0]  RSVD_INIT_DEF = 8'hA4;

  // Bank selected for the upper half of code space by a page value.
  function automatic int upper_bank(input int page, input int num_pages);
    return (page < num_pages) ? page + 1 : 1;
  endfunction
endpackage

// File: rtl/paged_code_xlat_page_reg.sv
module paged_code_xlat_page_reg
  import paged_code_xlat_pkg::*;
#(
  parameter int DATA_AW = DATA_AW_DEF,
  parameter int DW = DW_DEF,
  parameter int PAGE_BITS = PAGE_BITS_DEF,
  parameter logic [DATA_AW-1:0] PAGE_ADDR = PAGE_ADDR_DEF,
  parameter logic [DW-1:0] RSVD_INIT = RSVD_INIT_DEF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [DATA_AW-1:0]   dbus_addr,
  input  logic [DW-1:0]        dbus_wdata,
  input  logic                 dbus_wr,
  input  logic                 dbus_rd,
  output logic [PAGE_BITS-1:0] page_o,
  output logic [DW-1:0]        rdata_o
);
  localparam int RSVD_W = DW - PAGE_BITS;
  localparam logic [RSVD_W-1:0] RSVD_BITS = RSVD_INIT[DW-1:PAGE_BITS];

  logic sel;
  assign sel = (dbus_addr == PAGE_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      page_o  <= '0;
      rdata_o <= '0;
    end else begin
      if (dbus_wr && sel) page_o <= dbus_wdata[PAGE_BITS-1:0];
      if (dbus_rd && sel) rdata_o <= {RSVD_BITS, page_o};
      else                rdata_o <= '0;
    end
  end

  // R4: a write aimed elsewhere leaves the page untouched
  p_foreign_write_r4: assert property (@(posedge clk) disable iff (rst)
    (dbus_wr && !sel) |=> $stable(page_o));

  // R5: reserved field of read data is fixed
  p_rsvd_fixed_r5: assert property (@(posedge clk) disable iff (rst)
    (dbus_rd && sel) |=> (rdata_o[DW-1:PAGE_BITS] == RSVD_BITS));

  // R5: non-register cycles return zero
  p_idle_zero_r5: assert property (@(posedge clk) disable iff (rst)
    !(dbus_rd && sel) |=> (rdata_o == '0));
endmodule

// File: rtl/paged_code_xlat_boot_ctrl.sv
module paged_code_xlat_boot_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic release_i,
  output logic active_o,
  output logic restart_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      active_o  <= 1'b1;
      restart_o <= 1'b0;
    end else begin
      restart_o <= active_o && release_i;
      if (release_i) active_o <= 1'b0;
    end
  end

  // R7: once released, the overlay never returns without reset
  p_stay_released_r7: assert property (@(posedge clk) disable iff (rst)
    !active_o |=> !active_o);

  // R8: restart pulse is a single cycle
  p_restart_single_r8: assert property (@(posedge clk) disable iff (rst)
    restart_o |=> !restart_o);

  // R8: pulse accompanies the overlay dropping
  p_restart_on_fall_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(active_o) |-> restart_o);
endmodule

// File: rtl/paged_code_xlat_map.sv
module paged_code_xlat_map
  import paged_code_xlat_pkg::*;
#(
  parameter int CODE_AW = CODE_AW_DEF,
  parameter int PAGE_BITS = PAGE_BITS_DEF,
  parameter int NUM_PAGES = NUM_PAGES_DEF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CODE_AW-1:0]   code_addr,
  input  logic [PAGE_BITS-1:0] page_i,
  input  logic                 boot_i,
  output logic [CODE_AW-1+$clog2(NUM_PAGES+1)-1:0] flash_addr_o,
  output logic                 boot_hit_o
);
  localparam int HALF   = CODE_AW - 1;
  localparam int BW     = $clog2(NUM_PAGES + 1);
  localparam int FA     = HALF + BW;
  localparam int NCODES = 2 ** PAGE_BITS;

  logic [BW-1:0] bank_tbl [NCODES];

  genvar g;
  generate
    for (g = 0; g < NCODES; g++) begin : g_bank
      assign bank_tbl[g] = BW'(upper_bank(g, NUM_PAGES));
    end
  endgenerate

  logic [BW-1:0] bank;
  logic          hit;

  always_comb begin
    if (code_addr[HALF]) begin
      bank = bank_tbl[page_i];
      hit  = 1'b0;
    end else begin
      bank = '0;
      hit  = boot_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flash_addr_o <= '0;
      boot_hit_o   <= 1'b0;
    end else begin
      flash_addr_o <= {bank, code_addr[HALF-1:0]};
      boot_hit_o   <= hit;
    end
  end

  // R2: lower half lands in bank zero with unchanged offset
  p_low_common_r2: assert property (@(posedge clk) disable iff (rst)
    !code_addr[HALF] |=> (flash_addr_o == FA'($past(code_addr[HALF-1:0]))));

  // R3: upper half never lands in bank zero nor in boot
  p_upper_banked_r3: assert property (@(posedge clk) disable iff (rst)
    code_addr[HALF] |=> ((flash_addr_o[FA-1:HALF] != '0) && !boot_hit_o));

  // R6: no boot hit once the overlay is gone
  p_hit_needs_boot_r6: assert property (@(posedge clk) disable iff (rst)
    !boot_i |=> !boot_hit_o);
endmodule

// File: rtl/paged_code_xlat.sv
module paged_code_xlat
  import paged_code_xlat_pkg::*;
#(
  parameter int CODE_AW = CODE_AW_DEF,
  parameter int DATA_AW = DATA_AW_DEF,
  parameter int DW = DW_DEF,
  parameter int PAGE_BITS = PAGE_BITS_DEF,
  parameter int NUM_PAGES = NUM_PAGES_DEF,
  parameter logic [DATA_AW-1:0] PAGE_ADDR = PAGE_ADDR_DEF,
  parameter logic [DW-1:0] RSVD_INIT = RSVD_INIT_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CODE_AW-1:0] code_addr,
  input  logic [DATA_AW-1:0] dbus_addr,
  input  logic [DW-1:0]      dbus_wdata,
  input  logic               dbus_wr,
  input  logic               dbus_rd,
  input  logic               boot_release,
  output logic [CODE_AW-1+$clog2(NUM_PAGES+1)-1:0] flash_addr,
  output logic               boot_hit,
  output logic [DW-1:0]      dbus_rdata,
  output logic               cpu_restart
);
  logic [PAGE_BITS-1:0] page;
  logic                 boot_active;

  paged_code_xlat_page_reg #(
    .DATA_AW(DATA_AW), .DW(DW), .PAGE_BITS(PAGE_BITS),
    .PAGE_ADDR(PAGE_ADDR), .RSVD_INIT(RSVD_INIT)
  ) u_page (
    .clk(clk), .rst(rst), .dbus_addr(dbus_addr), .dbus_wdata(dbus_wdata),
    .dbus_wr(dbus_wr), .dbus_rd(dbus_rd), .page_o(page), .rdata_o(dbus_rdata)
  );

  paged_code_xlat_boot_ctrl u_boot (
    .clk(clk), .rst(rst), .release_i(boot_release),
    .active_o(boot_active), .restart_o(cpu_restart)
  );

  paged_code_xlat_map #(
    .CODE_AW(CODE_AW), .PAGE_BITS(PAGE_BITS), .NUM_PAGES(NUM_PAGES)
  ) u_map (
    .clk(clk), .rst(rst), .code_addr(code_addr), .page_i(page),
    .boot_i(boot_active), .flash_addr_o(flash_addr), .boot_hit_o(boot_hit)
  );
endmodule

// File: tb/paged_code_xlat_bench.sv
module paged_code_xlat_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] code_addr = '0;
  logic [15:0] dbus_addr = '0;
  logic [7:0]  dbus_wdata = '0;
  logic        dbus_wr = 1'b0, dbus_rd = 1'b0, boot_release = 1'b0;
  logic [16:0] flash_addr;
  logic        boot_hit, cpu_restart;
  logic [7:0]  dbus_rdata;

  always #10 clk = ~clk;

  paged_code_xlat u_paged_code_xlat (
    .clk(clk), .rst(rst), .code_addr(code_addr), .dbus_addr(dbus_addr),
    .dbus_wdata(dbus_wdata), .dbus_wr(dbus_wr), .dbus_rd(dbus_rd),
    .boot_release(boot_release), .flash_addr(flash_addr), .boot_hit(boot_hit),
    .dbus_rdata(dbus_rdata), .cpu_restart(cpu_restart)
  );

  int total = 0, bad = 0, cycles = 0;
  bit seen = 0;

  // behavioural reference state
  int m_page = 0;
  bit m_boot = 1;
  int e_flash = 0, e_rdata = 0;
  bit e_hit = 0, e_restart = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_page = 0; m_boot = 1;
      e_flash = 0; e_hit = 0; e_rdata = 0; e_restart = 0;
    end else begin
      if (code_addr[15]) begin
        e_flash = ((m_page < 3 ? m_page + 1 : 1) * 32768) + code_addr[14:0];
        e_hit = 0;
      end else begin
        e_flash = code_addr[14:0];
        e_hit = m_boot;
      end
      e_rdata   = (dbus_rd && dbus_addr == 16'hC0E0) ? (8'hA4 | m_page) : 0;
      e_restart = m_boot && boot_release;
      if (dbus_wr && dbus_addr == 16'hC0E0) m_page = dbus_wdata[1:0];
      if (boot_release) m_boot = 0;
    end
    seen = 1;
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (seen) begin
      if (e_hit)              chk(flash_addr == e_flash, "R6 R9 flash", flash_addr, e_flash);
      else if (e_flash >= 32768) chk(flash_addr == e_flash, "R3 R9 flash", flash_addr, e_flash);
      else                    chk(flash_addr == e_flash, "R2 R9 flash", flash_addr, e_flash);
      chk(boot_hit == e_hit, "R6 boot_hit", boot_hit, e_hit);
      chk(dbus_rdata == e_rdata, "R5 rdata", dbus_rdata, e_rdata);
      chk(cpu_restart == e_restart, "R8 restart", cpu_restart, e_restart);
    end
  end

  always @(posedge clk) begin
    if (cycles > 50000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step(input logic [15:0] ca, input logic [15:0] da,
                      input logic [7:0] wd, input bit wr, input bit rd, input bit rel);
    @(negedge clk);
    code_addr = ca; dbus_addr = da; dbus_wdata = wd;
    dbus_wr = wr; dbus_rd = rd; boot_release = rel;
  endtask

  task automatic idle(input logic [15:0] ca);
    step(ca, 16'h0000, 8'h00, 0, 0, 0);
  endtask

  task automatic wr_page(input logic [15:0] da, input logic [7:0] v);
    step(16'h0000, da, v, 1, 0, 0);
  endtask

  task automatic rd_page();
    step(16'h0000, 16'hC0E0, 8'h00, 0, 1, 0);
  endtask

  task automatic sweep();
    idle(16'h0000); idle(16'h1234); idle(16'h7FFF);
    idle(16'h8000); idle(16'hABCD); idle(16'hFFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state at ports
    chk(flash_addr == 0 && boot_hit == 0 && dbus_rdata == 0 && cpu_restart == 0,
        "R1 reset outputs", {flash_addr, boot_hit}, 0);
    @(negedge clk); rst = 0;
    rd_page(); idle(16'h0000);
    chk(dbus_rdata == 8'hA4, "R1 page after reset", dbus_rdata, 8'hA4);
    // boot overlay active, page 0
    sweep();
    // R4: pages 1, 2, 3 with all-ones upper data
    for (int p = 1; p < 4; p++) begin
      wr_page(16'hC0E0, 8'hFC | p[7:0]);
      rd_page(); idle(16'hC000);
      chk(dbus_rdata == (8'hA4 | p[7:0]), "R4 R5 page readback", dbus_rdata, 8'hA4 | p[7:0]);
      sweep();
    end
    // R4: foreign write ignored
    wr_page(16'hC0E1, 8'h01);
    rd_page(); idle(16'h0000);
    chk(dbus_rdata == 8'hA7, "R4 foreign write", dbus_rdata, 8'hA7);
    // release, same-cycle fetch still sees overlay (R7)
    step(16'h0100, 16'h0000, 8'h00, 0, 0, 1);
    idle(16'h0100);
    chk(boot_hit == 1 && cpu_restart == 1, "R7 R8 release edge", {boot_hit, cpu_restart}, 2'b11);
    idle(16'h0100);
    chk(boot_hit == 0 && cpu_restart == 0, "R7 R8 after release", {boot_hit, cpu_restart}, 0);
    // released: low half common across pages (R2)
    for (int p = 0; p < 4; p++) begin
      wr_page(16'hC0E0, p[7:0]);
      sweep();
    end
    // second release: no pulse, overlay stays off
    step(16'h0200, 16'h0000, 8'h00, 0, 0, 1);
    idle(16'h0200);
    chk(cpu_restart == 0 && boot_hit == 0, "R8 R7 second release", {boot_hit, cpu_restart}, 0);
    // write and read in the same cycle returns the old page
    step(16'h9000, 16'hC0E0, 8'h02, 1, 1, 0);
    idle(16'h9000);
    chk(dbus_rdata == 8'hA7, "R5 read before write", dbus_rdata, 8'hA7);
    idle(16'h9000);
    chk(flash_addr == 17'h19000, "R3 page 2 upper", flash_addr, 17'h19000);
    // second reset brings overlay back
    @(negedge clk); rst = 1;
    idle(16'h0000); idle(16'h0000);
    @(negedge clk); rst = 0;
    idle(16'h0040); idle(16'h0040);
    chk(boot_hit == 1, "R7 overlay after reset", boot_hit, 1);
    sweep();
    step(16'h0000, 16'h0000, 8'h00, 0, 0, 1);
    idle(16'h0000);
    chk(cpu_restart == 1, "R8 pulse after new reset", cpu_restart, 1);
    idle(16'h0000); idle(16'h0000);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule